// File: doc/BRIEF.md
# Mode-banked general register file

This block holds the general-purpose registers of a processor core whose register view depends on the current 5-bit operating mode. Two combinational read ports and one clocked write port address logical registers 0 to 14; the block steers each access to a physical entry picked from the mode. Registers 0 to 7 are common to every mode. The fast-interrupt mode has private copies of registers 8 to 14. The other exception modes have private copies of registers 13 and 14 only, and share 8 to 12 with the unprivileged view. The unprivileged mode and the privileged system mode use the same view. Any encoding that matches none of these modes also uses that view.

A separate access path reads and writes a saved-status register. Each exception mode has one. When software touches the saved-status path in a mode that has none, the block raises a flag, returns zero and drops the write. Register index 15 stands for the program counter, which is not stored here. It reads as zero and writes to it are ignored. A mode change leaves every banked copy as it was.

Top module: `banked_regfile`

## Requirements
- R1: Logical registers 0..7 map to the same storage in every mode. A value written in one mode reads back unchanged in any other mode.
- R2: Mode 5'b10001 (fast interrupt) has private copies of registers 8..14. Writes to them in that mode are not seen by other modes, and writes to 8..14 in other modes are not seen by it.
- R3: Modes 5'b10010, 5'b10011, 5'b10111, 5'b11011 and 5'b10110 each have private registers 13 and 14. They share registers 8..12 with mode 5'b10000.
- R4: Mode 5'b11111 sees the same registers as mode 5'b10000. Any mode encoding not listed in R2, R3 or R4 also maps to the mode 5'b10000 view.
- R5: Each of the six exception modes (listed in R2 and R3) owns a distinct saved-status register. `sr_rdata` shows the current mode's copy, and `sr_wr_en` writes it at the clock edge.
- R6: In a mode without saved status (R4), `sr_none` is 1 whenever `sr_rd_en` or `sr_wr_en` is 1, `sr_rdata` is 0, and a saved-status write changes no stored value. `sr_none` is 0 when neither enable is set.
- R7: A register write takes effect at the rising clock edge. A read of the written register in the same cycle returns the old value, and the next cycle returns the new value.
- R8: Index 15 on a read port returns zero. A write to index 15 changes no register.
- R9: Banked copies keep their contents across mode changes. On return to a mode, its registers read their earlier values.
- R10: A synchronous active-high reset clears every register and every saved-status register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Current operating mode encoding |
| rd_idx_a | input | 4 | Logical register index, read port A |
| rd_data_a | output | DATA_W | Read data, port A (combinational) |
| rd_idx_b | input | 4 | Logical register index, read port B |
| rd_data_b | output | DATA_W | Read data, port B (combinational) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical register index for the write |
| wr_data | input | DATA_W | Write data |
| sr_rd_en | input | 1 | Saved-status read access |
| sr_wr_en | input | 1 | Saved-status write enable |
| sr_wdata | input | SR_W | Saved-status write data |
| sr_rdata | output | SR_W | Saved-status read data for the current mode |
| sr_none | output | 1 | Saved-status access in a mode that has none |

## Verification
The bench builds the block with the default widths: 32-bit registers and 32-bit saved status. Full-width random values make a write steered to the wrong one of the 32 physical entries or 6 saved slots show up as a data mismatch. Mode choice includes two unlisted encodings, so the fallback to the unprivileged view is covered. Both read ports run alongside writes over thousands of mixed-mode cycles, which brings same-cycle read-after-write and cross-bank aliasing within reach.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

    localparam int MODE_W     = 5;
    localparam int IDX_W      = 4;
    localparam int NUM_BANKS  = 7;
    localparam int SHARED_LO  = 8;
    localparam int MID_CNT    = 5;
    localparam int HI_CNT     = 2;
    localparam int PC_IDX     = 15;
    localparam int HI_FIRST   = SHARED_LO + MID_CNT;
    localparam int HI_BASE    = SHARED_LO + 2 * MID_CNT;
    localparam int PHYS_REGS  = HI_BASE + HI_CNT * NUM_BANKS;
    localparam int PHYS_W     = $clog2(PHYS_REGS);
    localparam int NUM_SAVED  = NUM_BANKS - 1;
    localparam int SLOT_W     = $clog2(NUM_SAVED);

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_MON = 5'b10110,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } cpu_mode_e;

    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5,
        BANK_MON = 3'd6
    } bank_e;

    typedef struct packed {
        bank_e             bank;
        logic              has_saved;
        logic [SLOT_W-1:0] saved_slot;
    } mode_view_t;

    typedef struct packed {
        logic              valid;
        logic [PHYS_W-1:0] phys;
    } phys_sel_t;

    function automatic mode_view_t decode_mode(input logic [MODE_W-1:0] m);
        mode_view_t v;
        case (m)
            MODE_FIQ: v.bank = BANK_FIQ;
            MODE_IRQ: v.bank = BANK_IRQ;
            MODE_SVC: v.bank = BANK_SVC;
            MODE_ABT: v.bank = BANK_ABT;
            MODE_UND: v.bank = BANK_UND;
            MODE_MON: v.bank = BANK_MON;
            default:  v.bank = BANK_USR;
        endcase
        v.has_saved  = (v.bank != BANK_USR);
        v.saved_slot = v.has_saved ? SLOT_W'(int'(v.bank) - 1) : '0;
        return v;
    endfunction

    function automatic phys_sel_t map_index(input bank_e b, input logic [IDX_W-1:0] idx);
        phys_sel_t s;
        s.valid = 1'b1;
        s.phys  = '0;
        if (int'(idx) == PC_IDX) begin
            s.valid = 1'b0;
        end else if (int'(idx) < SHARED_LO) begin
            s.phys = PHYS_W'(int'(idx));
        end else if (int'(idx) < HI_FIRST) begin
            s.phys = (b == BANK_FIQ) ? PHYS_W'(int'(idx) + MID_CNT) : PHYS_W'(int'(idx));
        end else begin
            s.phys = PHYS_W'(HI_BASE + HI_CNT * int'(b) + int'(idx) - HI_FIRST);
        end
        return s;
    endfunction

endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
    import banked_rf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_view_t        view
);
    always_comb begin
        view = decode_mode(mode);
    end
endmodule

// File: rtl/brf_index_map.sv
module brf_index_map
    import banked_rf_pkg::*;
(
    input  bank_e            bank,
    input  logic [IDX_W-1:0] idx,
    output phys_sel_t        sel
);
    always_comb begin
        sel = map_index(bank, idx);
    end
endmodule

// File: rtl/brf_phys_array.sv
module brf_phys_array #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int NUM_RD = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr [NUM_RD],
    output logic [DATA_W-1:0] rdata [NUM_RD]
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rdata[p] = cells[raddr[p]];
    end
endmodule

// File: rtl/brf_saved_bank.sv
module brf_saved_bank #(
    parameter int SR_W  = 32,
    parameter int SLOTS = 6,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [SW-1:0]   slot,
    input  logic [SR_W-1:0] wdata,
    output logic [SR_W-1:0] rdata
);
    logic [SR_W-1:0] saved [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                saved[i] <= '0;
            end
        end else if (we) begin
            saved[slot] <= wdata;
        end
    end

    assign rdata = saved[slot];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SR_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        mode,
    input  logic [3:0]        rd_idx_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [3:0]        rd_idx_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sr_rd_en,
    input  logic              sr_wr_en,
    input  logic [SR_W-1:0]   sr_wdata,
    output logic [SR_W-1:0]   sr_rdata,
    output logic              sr_none
);
    localparam int NUM_RD = 2;

    mode_view_t        view;
    logic [IDX_W-1:0]  rd_idx   [NUM_RD];
    phys_sel_t         rd_sel   [NUM_RD];
    logic [PHYS_W-1:0] rd_addr  [NUM_RD];
    logic [DATA_W-1:0] rd_raw   [NUM_RD];
    logic [DATA_W-1:0] rd_out   [NUM_RD];
    phys_sel_t         wr_sel;
    logic [SR_W-1:0]   saved_raw;

    brf_mode_decode u_decode (
        .mode (mode),
        .view (view)
    );

    assign rd_idx[0] = rd_idx_a;
    assign rd_idx[1] = rd_idx_b;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rport
        brf_index_map u_rmap (
            .bank (view.bank),
            .idx  (rd_idx[p]),
            .sel  (rd_sel[p])
        );
        assign rd_addr[p] = rd_sel[p].phys;
        assign rd_out[p]  = rd_sel[p].valid ? rd_raw[p] : '0;
    end

    brf_index_map u_wmap (
        .bank (view.bank),
        .idx  (wr_idx),
        .sel  (wr_sel)
    );

    brf_phys_array #(
        .DATA_W (DATA_W),
        .DEPTH  (PHYS_REGS),
        .NUM_RD (NUM_RD)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && wr_sel.valid),
        .waddr (wr_sel.phys),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_raw)
    );

    assign rd_data_a = rd_out[0];
    assign rd_data_b = rd_out[1];

    brf_saved_bank #(
        .SR_W  (SR_W),
        .SLOTS (NUM_SAVED)
    ) u_saved (
        .clk   (clk),
        .rst   (rst),
        .we    (sr_wr_en && view.has_saved),
        .slot  (view.saved_slot),
        .wdata (sr_wdata),
        .rdata (saved_raw)
    );

    assign sr_rdata = view.has_saved ? saved_raw : '0;
    assign sr_none  = (sr_rd_en || sr_wr_en) && !view.has_saved;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
    parameter int DATA_W = 32,
    parameter int SR_W   = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [4:0]        mode,
    input logic [3:0]        rd_idx_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [3:0]        rd_idx_b,
    input logic [DATA_W-1:0] rd_data_b,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              sr_rd_en,
    input logic              sr_wr_en,
    input logic [SR_W-1:0]   sr_rdata,
    input logic              sr_none
);
    logic seen_run;
    logic exc_mode;

    always_ff @(posedge clk) begin
        if (rst) seen_run <= 1'b0;
        else     seen_run <= 1'b1;
    end

    assign exc_mode = mode inside {5'b10001, 5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11011};

    AST_PC_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == 4'd15 || rd_idx_b == 4'd15) |->
        ((rd_idx_a != 4'd15 || rd_data_a == '0) && (rd_idx_b != 4'd15 || rd_data_b == '0))); // R8

    AST_NO_SAVED_FLAG: assert property (@(posedge clk) disable iff (rst)
        (sr_rd_en || sr_wr_en) |-> (sr_none == !exc_mode)); // R6

    AST_NO_SAVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        sr_none |-> (sr_rdata == '0)); // R6

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != 4'd15) |=>
        ((rd_idx_a == $past(wr_idx) && mode == $past(mode)) -> (rd_data_a == $past(wr_data)))); // R7

    AST_LOW_SHARED: assert property (@(posedge clk) disable iff (rst)
        (seen_run && rd_idx_a < 4'd8 && $stable(rd_idx_a) && !$past(wr_en)) |->
        $stable(rd_data_a)); // R1
endmodule

bind banked_regfile banked_regfile_chk #(
    .DATA_W (DATA_W),
    .SR_W   (SR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .rd_idx_a  (rd_idx_a),
    .rd_data_a (rd_data_a),
    .rd_idx_b  (rd_idx_b),
    .rd_data_b (rd_data_b),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sr_rd_en  (sr_rd_en),
    .sr_wr_en  (sr_wr_en),
    .sr_rdata  (sr_rdata),
    .sr_none   (sr_none)
);

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;
    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_MON = 5'b10110;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mode = M_USR;
    logic [3:0]  rd_idx_a = '0, rd_idx_b = '0, wr_idx = '0;
    logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
    logic        wr_en = 1'b0, sr_rd_en = 1'b0, sr_wr_en = 1'b0;
    logic [31:0] sr_wdata = '0, sr_rdata;
    logic        sr_none;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    banked_regfile uut (
        .clk(clk), .rst(rst), .mode(mode),
        .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sr_rd_en(sr_rd_en), .sr_wr_en(sr_wr_en), .sr_wdata(sr_wdata),
        .sr_rdata(sr_rdata), .sr_none(sr_none)
    );

    // Reference model: per-view storage
    logic [31:0] m_low     [8];
    logic [31:0] m_usr_mid [5];
    logic [31:0] m_fiq_mid [5];
    logic [31:0] m_hi      [7][2];
    logic [31:0] m_sr      [7];

    function automatic int bk(input logic [4:0] m);
        case (m)
            M_FIQ:   return 1;
            M_IRQ:   return 2;
            M_SVC:   return 3;
            M_ABT:   return 4;
            M_UND:   return 5;
            M_MON:   return 6;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [4:0] m, input int i);
        if (i == 15) return 32'h0;
        if (i < 8) return m_low[i];
        if (i < 13) return (bk(m) == 1) ? m_fiq_mid[i-8] : m_usr_mid[i-8];
        return m_hi[bk(m)][i-13];
    endfunction

    function automatic string tag_for(input logic [4:0] m, input int i);
        if (i == 15) return "R8";
        if (i < 8) return "R1";
        if (bk(m) == 1) return "R2";
        if (bk(m) != 0) return "R3";
        return "R4";
    endfunction

    task automatic model_write(input logic [4:0] m, input int i, input logic [31:0] d);
        if (i == 15) return;
        if (i < 8) m_low[i] = d;
        else if (i < 13) begin
            if (bk(m) == 1) m_fiq_mid[i-8] = d;
            else m_usr_mid[i-8] = d;
        end else m_hi[bk(m)][i-13] = d;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic op(input logic [4:0] m, input int ia, input int ib,
                      input bit we, input int wi, input logic [31:0] wd,
                      input bit srr, input bit srw, input logic [31:0] swd);
        @(negedge clk);
        mode = m; rd_idx_a = 4'(ia); rd_idx_b = 4'(ib);
        wr_en = we; wr_idx = 4'(wi); wr_data = wd;
        sr_rd_en = srr; sr_wr_en = srw; sr_wdata = swd;
        #1;
        chk(tag_for(m, ia), rd_data_a, exp_rd(m, ia));
        chk(tag_for(m, ib), rd_data_b, exp_rd(m, ib));
        if (srr || srw) chk("R6", 32'(sr_none), 32'(bk(m) == 0));
        else            chk("R6", 32'(sr_none), 32'h0);
        if (srr) chk("R5", sr_rdata, (bk(m) == 0) ? 32'h0 : m_sr[bk(m)]);
        if (we) model_write(m, wi, wd);
        if (srw && bk(m) != 0) m_sr[bk(m)] = swd;
    endtask

    logic [4:0] mode_pool [10];
    logic [31:0] keep;

    initial begin
        mode_pool = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_MON, M_ABT, M_UND, M_SYS, 5'b00000, 5'b10100};
        for (int i = 0; i < 8; i++) m_low[i] = '0;
        for (int i = 0; i < 5; i++) begin m_usr_mid[i] = '0; m_fiq_mid[i] = '0; end
        for (int b = 0; b < 7; b++) begin m_hi[b][0] = '0; m_hi[b][1] = '0; m_sr[b] = '0; end
        void'($urandom(32'd2024));

        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R10: everything zero after reset
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 15; i++) begin
                op(mode_pool[k], i, 14 - i, 0, 0, 0, 1, 0, 0);
                chk("R10", rd_data_a, 32'h0);
                chk("R10", sr_rdata, 32'h0);
            end
        end

        // R1: low register shared across modes
        op(M_USR, 3, 0, 1, 3, 32'hA0A0_0003, 0, 0, 0);
        op(M_FIQ, 3, 3, 0, 0, 0, 0, 0, 0);
        chk("R1", rd_data_a, 32'hA0A0_0003);

        // R2: fast-interrupt bank for 8..14
        op(M_FIQ, 9, 0, 1, 9, 32'hF1F1_0009, 0, 0, 0);
        op(M_USR, 9, 0, 1, 9, 32'h1111_0009, 0, 0, 0);
        op(M_FIQ, 9, 14, 1, 14, 32'hF1F1_000E, 0, 0, 0);
        chk("R2", rd_data_a, 32'hF1F1_0009);
        op(M_USR, 9, 14, 0, 0, 0, 0, 0, 0);
        chk("R2", rd_data_a, 32'h1111_0009);
        chk("R2", rd_data_b, 32'h0);

        // R3: other exception modes share 8..12, private 13/14
        op(M_IRQ, 10, 13, 1, 10, 32'h2222_000A, 0, 0, 0);
        op(M_IRQ, 13, 0, 1, 13, 32'h2222_000D, 0, 0, 0);
        op(M_SVC, 13, 10, 0, 0, 0, 0, 0, 0);
        chk("R3", rd_data_a, 32'h0);
        chk("R3", rd_data_b, 32'h2222_000A);
        op(M_USR, 10, 13, 0, 0, 0, 0, 0, 0);
        chk("R3", rd_data_a, 32'h2222_000A);

        // R4: system and unlisted encodings use the unprivileged view
        op(M_SYS, 13, 0, 1, 13, 32'h5555_000D, 0, 0, 0);
        op(M_USR, 13, 9, 0, 0, 0, 0, 0, 0);
        chk("R4", rd_data_a, 32'h5555_000D);
        op(5'b00101, 13, 9, 0, 0, 0, 0, 0, 0);
        chk("R4", rd_data_a, 32'h5555_000D);
        chk("R4", rd_data_b, 32'h1111_0009);

        // R5: distinct saved-status per exception mode
        for (int k = 1; k < 7; k++) op(mode_pool[k], 0, 0, 0, 0, 0, 0, 1, 32'h5A00_0000 + 32'(k));
        for (int k = 1; k < 7; k++) begin
            op(mode_pool[k], 0, 0, 0, 0, 0, 1, 0, 0);
            chk("R5", sr_rdata, 32'h5A00_0000 + 32'(k));
        end

        // R6: no saved-status in unprivileged views
        op(M_USR, 0, 0, 0, 0, 0, 1, 1, 32'hDEAD_BEEF);
        chk("R6", 32'(sr_none), 32'h1);
        chk("R6", sr_rdata, 32'h0);
        op(M_SYS, 0, 0, 0, 0, 0, 0, 1, 32'hDEAD_BEEF);
        for (int k = 1; k < 7; k++) begin
            op(mode_pool[k], 0, 0, 0, 0, 0, 1, 0, 0);
            chk("R6", sr_rdata, 32'h5A00_0000 + 32'(k));
        end
        op(M_USR, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R6", 32'(sr_none), 32'h0);

        // R7: same-cycle read returns old value
        op(M_ABT, 5, 5, 1, 5, 32'h0000_0055, 0, 0, 0);
        chk("R7", rd_data_a, 32'h0);
        op(M_ABT, 5, 0, 0, 0, 0, 0, 0, 0);
        chk("R7", rd_data_a, 32'h0000_0055);

        // R8: index 15
        op(M_USR, 15, 15, 1, 15, 32'hFFFF_FFFF, 0, 0, 0);
        op(M_FIQ, 15, 0, 0, 0, 0, 0, 0, 0);
        chk("R8", rd_data_a, 32'h0);
        for (int i = 0; i < 15; i++) op(M_USR, i, 15, 0, 0, 0, 0, 0, 0);

        // R9: banked copies survive mode changes
        op(M_ABT, 14, 0, 1, 14, 32'hABAB_000E, 0, 0, 0);
        op(M_UND, 14, 0, 1, 14, 32'hCDCD_000E, 0, 0, 0);
        op(M_MON, 14, 0, 1, 14, 32'hEFEF_000E, 0, 0, 0);
        op(M_ABT, 14, 0, 0, 0, 0, 0, 0, 0);
        chk("R9", rd_data_a, 32'hABAB_000E);
        op(M_UND, 14, 0, 0, 0, 0, 0, 0, 0);
        chk("R9", rd_data_a, 32'hCDCD_000E);

        // Random mix over all modes
        for (int n = 0; n < 4000; n++) begin
            keep = $urandom;
            op(mode_pool[$urandom_range(9, 0)], int'($urandom_range(15, 0)), int'($urandom_range(15, 0)),
               bit'($urandom_range(1, 0)), int'($urandom_range(15, 0)), keep,
               ($urandom_range(3, 0) == 0), ($urandom_range(3, 0) == 0), ~keep);
        end
        op(M_USR, 0, 0, 0, 0, 0, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule